// File: doc/BRIEF.md
# Lookup-Table Numerically Controlled Oscillator

This block produces a pair of quadrature samples, sine and cosine, for a digital carrier-recovery loop. It holds a fixed-point phase pointer that measures position within one sine cycle in units of table entries. On every sample strobe, a programmable nominal step word and a signed correction from the loop filter are added to that pointer. The integer part of the pointer then addresses a 256-entry table that holds one full sine cycle.

The pointer is 16 bits wide, with 7 fractional bits below the binary point. The bit above bit 14 is forced to zero after every add, so the phase wraps once per table cycle. The fraction is never thrown away. A step that is not a whole number of entries therefore builds up carry into the integer part, and the average frequency stays exact over long runs. The table is read lower-neighbour: the fraction takes no part in the lookup. Cosine is read from the same table, a quarter cycle ahead of sine.

Top module: `lut_nco`

## Requirements
- R1: Table entry k holds the Q1.15 value of sin(2*pi*k/256): the magnitude is round(32768*|sin|) clipped to 32767, with the sign of the sine. Entries 0 and 128 are zero, entry 64 is 32767 and entry 192 is -32767.
- R2: The pointer output is 16 bits: bits 14..7 are the integer part and bits 6..0 the fraction. Bit 15 is always zero, so the pointer stays at or above 0 and below 256 entries.
- R3: On a clock edge with the strobe high, the pointer becomes (pointer + step + sign-extended offset) modulo 2^15. The offset uses the same 7-fractional-bit scale as the step.
- R4: The fraction is carried between samples. With step 2048 (16 entries) and zero offset, the fraction never changes. With a fractional step such as 2085, the pointer follows the exact modular sum.
- R5: On a clock edge with the strobe low, the pointer holds its value and ignores the step and offset inputs.
- R6: The sine output equals table[pointer bits 14..7] and is registered. It shows the entry for a new pointer value one clock after the edge that loaded that pointer.
- R7: The cosine output equals table[(pointer bits 14..7 + 64) mod 256], with the same one-clock latency as sine.
- R8: A negative offset that takes the sum below zero wraps to the top of the cycle. For example, pointer 0 with step 0 and offset -128 gives pointer 0x7F80 (entry 255).
- R9: A synchronous active-high reset sets the pointer, sine and cosine outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| strobe_i | input | 1 | Sample strobe; advances the pointer for one step |
| step_i | input | 15 | Nominal phase increment, 7 fractional bits |
| offset_i | input | 12 | Signed loop phase correction, 7 fractional bits |
| sin_o | output | 16 | Registered sine sample, signed Q1.15 |
| cos_o | output | 16 | Registered cosine sample, signed Q1.15 |
| ptr_o | output | 16 | Raw phase pointer, 9.7 fixed point |

## Verification
The embedded properties need the strobe, step and offset to be stable at each rising edge, and they need one full clock after reset before the table outputs are compared. The peak and zero-crossing checks only fire once that first post-reset load has happened. The bench changes its inputs on falling edges and holds the strobe for exactly one clock. It keeps the offset inside the 12-bit signed range, so each sum in the model is the same modular sum the block forms.

// File: rtl/nco_pkg.sv
package nco_pkg;
    localparam int PTR_W  = 16;
    localparam int FRAC_W = 7;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 16;
endpackage

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
    parameter int PTR_W  = nco_pkg::PTR_W,
    parameter int FRAC_W = nco_pkg::FRAC_W,
    parameter int OFS_W  = 12,
    localparam int STEP_W = PTR_W - 1
) (
    input  logic                    clk_i,
    input  logic                    rst_i,
    input  logic                    strobe_i,
    input  logic [STEP_W-1:0]       step_i,
    input  logic signed [OFS_W-1:0] offset_i,
    output logic [PTR_W-1:0]        ptr_o
);
    typedef struct packed {
        logic [PTR_W-1:0] ptr;
    } acc_state_t;

    acc_state_t state_d, state_q;
    logic [PTR_W-1:0] ofs_ext;
    logic [PTR_W-1:0] sum;

    always_comb begin
        state_d = state_q;
        ofs_ext = PTR_W'(offset_i);  // sign-extended through signed source
        sum     = state_q.ptr + {1'b0, step_i} + ofs_ext;
        if (strobe_i) begin
            state_d.ptr = {1'b0, sum[STEP_W-1:0]};
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= '0;
        else       state_q <= state_d;
    end

    assign ptr_o = state_q.ptr;

    // R5: no strobe, no movement
    a_r5_hold_no_strobe: assert property (@(posedge clk_i) disable iff (rst_i)
        !strobe_i |=> $stable(ptr_o));

    // R2: pointer stays below one table cycle
    a_r2_below_cycle: assert property (@(posedge clk_i) disable iff (rst_i)
        ptr_o[PTR_W-1] == 1'b0);

    // R4: an integer step with no correction leaves the fraction untouched
    a_r4_whole_step_keeps_frac: assert property (@(posedge clk_i) disable iff (rst_i)
        (strobe_i && offset_i == '0 && step_i[FRAC_W-1:0] == '0)
        |=> ptr_o[FRAC_W-1:0] == $past(ptr_o[FRAC_W-1:0]));
endmodule

// File: rtl/nco_sine_rom.sv
module nco_sine_rom #(
    parameter int ADDR_W = nco_pkg::ADDR_W,
    parameter int DATA_W = nco_pkg::DATA_W,
    localparam int DEPTH   = 1 << ADDR_W,
    localparam int HALF    = DEPTH / 2,
    localparam int QUARTER = DEPTH / 4
) (
    input  logic                     clk_i,
    input  logic                     rst_i,
    input  logic [ADDR_W-1:0]        addr_a_i,
    input  logic [ADDR_W-1:0]        addr_b_i,
    output logic signed [DATA_W-1:0] data_a_o,
    output logic signed [DATA_W-1:0] data_b_o
);
    localparam longint FULL   = longint'(1) << (DATA_W - 1);
    localparam longint PI_Q30 = 64'sd3373259426;

    // round(FULL * sin(m*pi/HALF)) for m in 0..QUARTER, Taylor series in Q30
    function automatic longint first_quadrant(input int m);
        longint x, x2, term, acc;
        x    = (PI_Q30 * longint'(m)) / longint'(HALF);
        x2   = (x * x) >>> 30;
        term = x;
        acc  = x;
        for (int n = 1; n <= 8; n++) begin
            term = -(((term * x2) >>> 30) / longint'((2 * n) * (2 * n + 1)));
            acc  = acc + term;
        end
        return (acc * FULL + (longint'(1) <<< 29)) >>> 30;
    endfunction

    function automatic logic signed [DATA_W-1:0] entry(input int k);
        int     idx;
        longint mag;
        idx = k % HALF;
        mag = first_quadrant((idx <= QUARTER) ? idx : HALF - idx);
        if (mag > FULL - 1) mag = FULL - 1;
        if (k >= HALF) mag = -mag;
        return DATA_W'(mag);
    endfunction

    logic signed [DATA_W-1:0] table_w [DEPTH];

    for (genvar k = 0; k < DEPTH; k++) begin : g_entry
        assign table_w[k] = entry(k);
    end

    typedef struct packed {
        logic signed [DATA_W-1:0] a;
        logic signed [DATA_W-1:0] b;
        logic                     primed;
    } rom_state_t;

    rom_state_t state_d, state_q;

    always_comb begin
        state_d.a      = table_w[addr_a_i];
        state_d.b      = table_w[addr_b_i];
        state_d.primed = 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= '0;
        else       state_q <= state_d;
    end

    assign data_a_o = state_q.a;
    assign data_b_o = state_q.b;

    // R1: quarter-cycle peak is the saturated positive full scale
    a_r1_peak_entry: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q.primed && $past(addr_a_i) == ADDR_W'(QUARTER))
        |-> data_a_o == DATA_W'(FULL - 1));

    // R1: zero crossings of the cycle read as zero
    a_r1_zero_entry: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q.primed && ($past(addr_b_i) == '0 || $past(addr_b_i) == ADDR_W'(HALF)))
        |-> data_b_o == '0);

    // R6: a steady address gives a steady registered sample
    a_r6_steady_read: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q.primed && $stable(addr_a_i)) |=> $stable(data_a_o));
endmodule

// File: rtl/lut_nco.sv
module lut_nco #(
    parameter int PTR_W  = nco_pkg::PTR_W,
    parameter int FRAC_W = nco_pkg::FRAC_W,
    parameter int ADDR_W = nco_pkg::ADDR_W,
    parameter int DATA_W = nco_pkg::DATA_W,
    parameter int OFS_W  = 12,
    localparam int STEP_W  = PTR_W - 1,
    localparam int QUARTER = (1 << ADDR_W) / 4
) (
    input  logic                     clk_i,
    input  logic                     rst_i,
    input  logic                     strobe_i,
    input  logic [STEP_W-1:0]        step_i,
    input  logic signed [OFS_W-1:0]  offset_i,
    output logic signed [DATA_W-1:0] sin_o,
    output logic signed [DATA_W-1:0] cos_o,
    output logic [PTR_W-1:0]         ptr_o
);
    logic [PTR_W-1:0]  ptr_w;
    logic [ADDR_W-1:0] sin_addr;
    logic [ADDR_W-1:0] cos_addr;

    nco_phase_acc #(
        .PTR_W (PTR_W),
        .FRAC_W(FRAC_W),
        .OFS_W (OFS_W)
    ) u_acc (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .strobe_i(strobe_i),
        .step_i  (step_i),
        .offset_i(offset_i),
        .ptr_o   (ptr_w)
    );

    // lower-neighbour selection: integer part only
    assign sin_addr = ptr_w[FRAC_W +: ADDR_W];
    assign cos_addr = sin_addr + ADDR_W'(QUARTER);

    nco_sine_rom #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_rom (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .addr_a_i(sin_addr),
        .addr_b_i(cos_addr),
        .data_a_o(sin_o),
        .data_b_o(cos_o)
    );

    assign ptr_o = ptr_w;

    // R7: cosine at a sine zero crossing is a full-scale peak
    a_r7_cos_peak_at_zero: assert property (@(posedge clk_i) disable iff (rst_i)
        ($past(sin_addr) == '0 && $past(rst_i) == 1'b0) |-> cos_o > DATA_W'(32000));
endmodule

// File: tb/lut_nco_bench.sv
module lut_nco_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 10;
    localparam int VEC_STEP [NV] = '{2085, 2085, 2048, 32767, 100, 0, 2085, 16384, 5, 2085};
    localparam int VEC_OFS  [NV] = '{0, -300, 500, 2047, -2048, -1, 37, 0, 0, -90};

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               strobe = 1'b0;
    logic [14:0]        step = '0;
    logic signed [11:0] ofs = '0;
    logic signed [15:0] sin_w, cos_w;
    logic [15:0]        ptr_w;

    int checks = 0;
    int fails  = 0;
    int model  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    lut_nco u_lut_nco (
        .clk_i(clk), .rst_i(rst), .strobe_i(strobe), .step_i(step),
        .offset_i(ofs), .sin_o(sin_w), .cos_o(cos_w), .ptr_o(ptr_w)
    );

    function automatic int ref_entry(input int k);
        real v;
        int  mag;
        v   = $sin(2.0 * 3.14159265358979 * real'(k % 256) / 256.0) * 32768.0;
        mag = (v < 0.0) ? $rtoi(-v + 0.5) : $rtoi(v + 0.5);
        if (mag > 32767) mag = 32767;
        return (v < 0.0) ? -mag : mag;
    endfunction

    task automatic check_int(input string req, input int act, input int exp, input int tol);
        checks++;
        if (act - exp > tol || exp - act > tol) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; strobe = 1'b0;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        model = 0;
    endtask

    // one strobe; checks pointer after the load edge, samples after the next
    task automatic step_once(input int s, input int o, input bit chk_out, input string req);
        step = 15'(s); ofs = 12'(o); strobe = 1'b1;
        @(negedge clk);
        strobe = 1'b0;
        model = (model + s + o) & 16'h7FFF;
        check_int(req, int'(ptr_w), model, 0);
        if (chk_out) begin
            @(negedge clk);
            check_int("R6", int'(sin_w), ref_entry(model >> 7), 1);
            check_int("R7", int'(cos_w), ref_entry((model >> 7) + 64), 1);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        check_int("R9", int'(ptr_w), 0, 0);
        check_int("R9", int'(sin_w), 0, 0);
        check_int("R9", int'(cos_w), 0, 0);
        rst = 1'b0;
        @(negedge clk); @(negedge clk);
        check_int("R7", int'(cos_w), 32767, 0);

        // vector table walk (R3, R4)
        for (int i = 0; i < NV; i++) step_once(VEC_STEP[i], VEC_OFS[i], 1'b1, "R3");

        // R5: inputs change without a strobe, pointer holds
        step = 15'd12345; ofs = -12'sd7;
        repeat (4) @(negedge clk);
        check_int("R5", int'(ptr_w), model, 0);
        check_int("R5", int'(sin_w), ref_entry(model >> 7), 1);

        // R4: whole-entry step keeps fraction
        for (int i = 0; i < 16; i++) step_once(2048, 0, 1'b0, "R4");
        check_int("R4", int'(ptr_w) & 127, model & 127, 0);

        // R4: long fractional run against the model
        for (int i = 0; i < 300; i++) step_once(2085, 0, (i % 25) == 0, "R4");

        // R8: negative wrap below zero
        do_reset();
        step_once(0, -128, 1'b1, "R8");
        check_int("R8", int'(ptr_w), 16'h7F80, 0);

        // R1: walk every table entry with one-entry steps
        do_reset();
        @(negedge clk);
        check_int("R1", int'(sin_w), 0, 0);
        for (int k = 1; k < 256; k++) begin
            step_once(128, 0, 1'b0, "R2");
            @(negedge clk);
            check_int("R1", int'(sin_w), ref_entry(k), 1);
            if (k == 64)  check_int("R1", int'(sin_w), 32767, 0);
            if (k == 192) check_int("R1", int'(sin_w), -32767, 0);
            if (k == 128) check_int("R1", int'(sin_w), 0, 0);
        end
        step_once(128, 0, 1'b0, "R2");
        check_int("R2", int'(ptr_w), 0, 0);
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule